// File: doc/BRIEF.md
# Square Wave Tone Channel

This block is one voice of a sound chip. It produces a rectangular tone at a programmed pitch and duty, scaled by a volume envelope and gated by a length counter. Software configures it by writing bytes to four registers: wave shape and length, envelope, pitch low byte, and pitch high bits with control. The same register addresses can be read back, and the bits that cannot be read return as ones.

Three one-cycle strobes come from outside. `tickEn` advances the pitch timer, `lenTick` clocks the length counter and `envTick` clocks the envelope. The output is a 4-bit digital sample, and mixing it with other voices happens elsewhere. A trigger write starts a note. The waveform position does not move at all until the first trigger after reset or power-off. A power-off input clears every setting and all internal state.

Top module: `sqToneChannel`

## Requirements
- R1: Register addresses are as follows. Address 0 holds the duty select in bits 7:6 and the length load in bits 5:0. Address 1 holds the initial volume in bits 7:4, the envelope direction in bit 3 (1 means rising) and the envelope period in bits 2:0. Address 2 holds pitch bits 7:0. Address 3 holds the trigger in bit 7, the length enable in bit 6 and pitch bits 10:8 in bits 2:0. A write takes effect on the edge where `wrEn` is high. Writing one half of the 11-bit pitch `f` leaves the other half unchanged.
- R2: After a trigger, the waveform position advances once every (2048 − f) `tickEn` pulses. The timer period is (2048 − f)×4 and each pulse lowers it by 4. A timer value of zero is replaced by the period first.
- R3: The waveform position is 3 bits wide and wraps from 7 to 0. It stays at 0, whatever `tickEn` does, until the first trigger after reset or power-off.
- R4: Each duty select has an 8-step pattern, written here from position 0 (leftmost) to position 7. Duty 0 is 00000001, duty 1 is 10000001, duty 2 is 10000111 and duty 3 is 01111110.
- R5: `sample` equals the current volume when the channel is active, the converter is enabled and the selected pattern bit at the current position is 1. In every other case `sample` is 0.
- R6: A trigger reloads the timer to the full period, loads the volume from the initial volume and reloads the envelope timer. It does not move the waveform position. The channel becomes active only if the converter is enabled.
- R7: The converter is enabled when bits 7:3 of address 1 are not all zero. A write that makes them all zero makes `active` 0 at that edge.
- R8: Writing address 0 sets the length counter to 64 − load. While the length enable is set, each `lenTick` decrements a nonzero counter, and reaching 0 makes the channel inactive. A trigger with the counter at 0 sets it to 64. While the length enable is clear, `lenTick` has no effect.
- R9: With an envelope period p ≠ 0, the volume steps by 1 every p `envTick` pulses in the chosen direction, saturating at 15 and at 0. With p = 0 the volume holds.
- R10: Reads are combinational on `rdAddr`. Address 0 returns {duty, 111111}. Address 1 returns the written byte. Address 2 returns 0xFF. Address 3 returns 0xBF with the length enable in bit 6.
- R11: A cycle with `powerDn` high clears every register field, the counters, the volume, the waveform position and the trigger-seen flag. Reset leaves the same state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| powerDn | input | 1 | Synchronous clear of all state |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 8 | Read data with unreadable bits set to one |
| tickEn | input | 1 | Pitch timer strobe |
| lenTick | input | 1 | Length counter strobe |
| envTick | input | 1 | Envelope strobe |
| sample | output | 4 | Digital output sample |
| active | output | 1 | Channel is sounding |

## Verification
All state changes on the edge that samples a write or a strobe. `sample` and `active` therefore show the new value one edge after the stimulus. `rdData` follows `rdAddr` in the same cycle, with no register in the path. The driver applies each write or strobe for exactly one edge and then queues its expected values. The monitor compares them shortly after the following falling edge, before any further edge can disturb them. Waveform steps are predicted from a position count kept in the bench, advancing once every (2048 − f) pulses.

// File: rtl/sqPkg.sv
package sqPkg;
  localparam int FREQ_W = 11;
  localparam int DUTY_W = 2;
  localparam int POS_W  = 3;
  localparam int VOL_W  = 4;
  localparam int LEN_W  = 6;
  localparam int ENV_W  = 3;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef struct packed {
    logic [DUTY_W-1:0] duty;
    logic [VOL_W-1:0]  initVol;
    logic              envUp;
    logic [ENV_W-1:0]  envPer;
    logic [FREQ_W-1:0] freq;
    logic              lenEn;
    logic              dacOn;
  } sqFields_t;

  typedef struct packed {
    logic              clear;
    logic              trigger;
    logic [FREQ_W-1:0] trigFreq;
    logic              lenLoad;
    logic [LEN_W-1:0]  lenVal;
    logic              dacKill;
  } sqStrobe_t;

  // Pattern strings are stored with position 0 in the most significant bit.
  function automatic logic dutyBit(input logic [DUTY_W-1:0] duty, input logic [POS_W-1:0] pos);
    logic [7:0] pat;
    case (duty)
      2'd0:    pat = 8'b0000_0001;
      2'd1:    pat = 8'b1000_0001;
      2'd2:    pat = 8'b1000_0111;
      default: pat = 8'b0111_1110;
    endcase
    return pat[3'd7 - pos];
  endfunction
endpackage

// File: rtl/sqCtrl.sv
module sqCtrl
  import sqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerDn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output sqFields_t         fields,
  output sqStrobe_t         strobes
);
  localparam logic [ADDR_W-1:0] ADDR_SHAPE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ENV   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLO   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd3;
  localparam int HI_W = FREQ_W - DATA_W;

  logic wrGo;
  assign wrGo = wrEn && !powerDn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fields <= '0;
    end else if (powerDn) begin
      fields <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_SHAPE: fields.duty <= wrData[DATA_W-1 -: DUTY_W];
        ADDR_ENV: begin
          fields.initVol <= wrData[DATA_W-1 -: VOL_W];
          fields.envUp   <= wrData[ENV_W];
          fields.envPer  <= wrData[ENV_W-1:0];
          fields.dacOn   <= |wrData[DATA_W-1:ENV_W];
        end
        ADDR_FLO:  fields.freq[DATA_W-1:0] <= wrData;
        default: begin
          fields.freq[FREQ_W-1:DATA_W] <= wrData[HI_W-1:0];
          fields.lenEn <= wrData[6];
        end
      endcase
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.clear    = powerDn;
    strobes.trigger  = wrGo && (wrAddr == ADDR_CTRL) && wrData[7];
    strobes.trigFreq = {wrData[HI_W-1:0], fields.freq[DATA_W-1:0]};
    strobes.lenLoad  = wrGo && (wrAddr == ADDR_SHAPE);
    strobes.lenVal   = wrData[LEN_W-1:0];
    strobes.dacKill  = wrGo && (wrAddr == ADDR_ENV) && !(|wrData[DATA_W-1:ENV_W]);
  end

  always_comb begin
    case (rdAddr)
      ADDR_SHAPE: rdData = {fields.duty, {(DATA_W-DUTY_W){1'b1}}};
      ADDR_ENV:   rdData = {fields.initVol, fields.envUp, fields.envPer};
      ADDR_FLO:   rdData = '1;
      default:    rdData = {1'b1, fields.lenEn, {(DATA_W-2){1'b1}}};
    endcase
  end
endmodule

// File: rtl/sqLength.sv
module sqLength #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             load,
  input  logic [LEN_W-1:0] loadVal,
  input  logic             trigger,
  input  logic             enable,
  input  logic             tick,
  output logic             expire
);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << LEN_W;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= FULL - CNT_W'(loadVal);
    end else if (trigger) begin
      if (cnt == '0) cnt <= FULL;
    end else if (tick && enable && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = !clear && !load && !trigger && tick && enable && (cnt == CNT_W'(1));
endmodule

// File: rtl/sqEnvelope.sv
module sqEnvelope #(
  parameter int VOL_W = 4,
  parameter int ENV_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             trigger,
  input  logic             tick,
  input  logic [VOL_W-1:0] initVol,
  input  logic             up,
  input  logic [ENV_W-1:0] period,
  output logic [VOL_W-1:0] volume
);
  localparam logic [VOL_W-1:0] VOL_MAX = '1;

  logic [ENV_W-1:0] envTmr, tmrDec;
  logic [VOL_W-1:0] volStep;

  always_comb begin
    tmrDec  = (envTmr != '0) ? envTmr - 1'b1 : '0;
    volStep = volume;
    if (up && volume != VOL_MAX)       volStep = volume + 1'b1;
    else if (!up && volume != '0)      volStep = volume - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      volume <= '0;
      envTmr <= '0;
    end else if (clear) begin
      volume <= '0;
      envTmr <= '0;
    end else if (trigger) begin
      volume <= initVol;
      envTmr <= period;
    end else if (tick && period != '0) begin
      if (tmrDec == '0) begin
        envTmr <= period;
        volume <= volStep;
      end else begin
        envTmr <= tmrDec;
      end
    end
  end
endmodule

// File: rtl/sqDatapath.sv
module sqDatapath
  import sqPkg::*;
#(
  parameter int TMR_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             lenTick,
  input  logic             envTick,
  input  sqFields_t        fields,
  input  sqStrobe_t        strobes,
  output logic [VOL_W-1:0] sample,
  output logic             active,
  output logic [POS_W-1:0] dutyPos,
  output logic             armed,
  output logic [VOL_W-1:0] volume
);
  localparam int TMR_W = FREQ_W + 1 + $clog2(TMR_STEP);
  localparam logic [TMR_W-1:0] STEP_V = TMR_W'(TMR_STEP);

  function automatic logic [TMR_W-1:0] periodOf(input logic [FREQ_W-1:0] f);
    return ((TMR_W'(1) << FREQ_W) - TMR_W'(f)) * STEP_V;
  endfunction

  logic [TMR_W-1:0] timer, runPeriod, trigPeriod, curT;
  logic lenExpire;

  assign runPeriod  = periodOf(fields.freq);
  assign trigPeriod = periodOf(strobes.trigFreq);
  assign curT       = (timer == '0) ? runPeriod : timer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer   <= '0;
      dutyPos <= '0;
      armed   <= 1'b0;
    end else if (strobes.clear) begin
      timer   <= '0;
      dutyPos <= '0;
      armed   <= 1'b0;
    end else if (strobes.trigger) begin
      timer <= trigPeriod;
      armed <= 1'b1;
    end else if (tickEn) begin
      if (curT > STEP_V) begin
        timer <= curT - STEP_V;
      end else begin
        timer <= runPeriod;
        if (armed) dutyPos <= dutyPos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              active <= 1'b0;
    else if (strobes.clear)                 active <= 1'b0;
    else if (strobes.trigger)               active <= fields.dacOn;
    else if (strobes.dacKill || lenExpire)  active <= 1'b0;
  end

  sqLength #(.LEN_W(LEN_W)) u_len (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (strobes.clear),
    .load    (strobes.lenLoad),
    .loadVal (strobes.lenVal),
    .trigger (strobes.trigger),
    .enable  (fields.lenEn),
    .tick    (lenTick),
    .expire  (lenExpire)
  );

  sqEnvelope #(.VOL_W(VOL_W), .ENV_W(ENV_W)) u_env (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (strobes.clear),
    .trigger (strobes.trigger),
    .tick    (envTick),
    .initVol (fields.initVol),
    .up      (fields.envUp),
    .period  (fields.envPer),
    .volume  (volume)
  );

  assign sample = (active && fields.dacOn && dutyBit(fields.duty, dutyPos)) ? volume : '0;
endmodule

// File: rtl/sqToneChannel.sv
module sqToneChannel
  import sqPkg::*;
#(
  parameter int TMR_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerDn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              tickEn,
  input  logic              lenTick,
  input  logic              envTick,
  output logic [VOL_W-1:0]  sample,
  output logic              active
);
  sqFields_t        fields;
  sqStrobe_t        strobes;
  logic [POS_W-1:0] dutyPos;
  logic             armed;
  logic [VOL_W-1:0] volume;

  sqCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .powerDn (powerDn),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .fields  (fields),
    .strobes (strobes)
  );

  sqDatapath #(.TMR_STEP(TMR_STEP)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .lenTick (lenTick),
    .envTick (envTick),
    .fields  (fields),
    .strobes (strobes),
    .sample  (sample),
    .active  (active),
    .dutyPos (dutyPos),
    .armed   (armed),
    .volume  (volume)
  );
endmodule

// File: rtl/sqToneChannel_chk.sv
module sqToneChannel_chk (
  input logic       clk,
  input logic       rstN,
  input logic       powerDn,
  input logic       wrEn,
  input logic [1:0] wrAddr,
  input logic [7:0] wrData,
  input logic       envTick,
  input logic [3:0] sample,
  input logic       active,
  input logic [2:0] dutyPos,
  input logic       armed,
  input logic [3:0] volume
);
  a_r5_silent_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> sample == 4'd0);

  a_r7_dac_off_stops: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !powerDn && wrAddr == 2'd1 && wrData[7:3] == 5'd0) |=> !active);

  a_r11_power_clears: assert property (@(posedge clk) disable iff (!rstN)
    powerDn |=> (!active && !armed && dutyPos == 3'd0 && volume == 4'd0));

  a_r3_frozen_until_trigger: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> dutyPos == 3'd0);

  a_r9_volume_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!envTick && !powerDn && !(wrEn && wrAddr == 2'd3 && wrData[7])) |=> $stable(volume));
endmodule

bind sqToneChannel sqToneChannel_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .powerDn (powerDn),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .envTick (envTick),
  .sample  (sample),
  .active  (active),
  .dutyPos (dutyPos),
  .armed   (armed),
  .volume  (volume)
);

// File: tb/sqToneChannel_tb.sv
`timescale 1ns/1ps
module sqToneChannel_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       powerDn = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       tickEn = 1'b0;
  logic       lenTick = 1'b0;
  logic       envTick = 1'b0;
  logic [3:0] sample;
  logic       active;

  always #2.5 clk = ~clk;

  sqToneChannel u_dut (
    .clk(clk), .rstN(rstN), .powerDn(powerDn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .tickEn(tickEn),
    .lenTick(lenTick), .envTick(envTick), .sample(sample), .active(active)
  );

  typedef struct { string tag; int sel; int exp; } item_t;
  item_t q[$];
  item_t cur;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int pos = 0;

  // Monitor: compares queued expectations shortly after each falling edge.
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      int act;
      cur = q.pop_front();
      case (cur.sel)
        0:       act = int'(sample);
        1:       act = int'(active);
        default: act = int'(rdData);
      endcase
      checks++;
      if (act != cur.exp) begin
        failures++;
        $display("FAIL %s actual=%0h expected=%0h", cur.tag, act, cur.exp);
      end
    end
  end

  function automatic int patBit(int d, int p);
    logic [7:0] v;
    case (d)
      0:       v = 8'b0000_0001;
      1:       v = 8'b1000_0001;
      2:       v = 8'b1000_0111;
      default: v = 8'b0111_1110;
    endcase
    return int'(v[7-p]);
  endfunction

  task automatic expectV(string tag, int sel, int val);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = val;
    q.push_back(it);
  endtask

  task automatic rd(logic [1:0] a, string tag, int val);
    @(negedge clk);
    rdAddr = a;
    expectV(tag, 2, val);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doTick(int n);
    repeat (n) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic doLen(int n);
    repeat (n) begin
      @(negedge clk); lenTick = 1'b1;
      @(negedge clk); lenTick = 1'b0;
    end
  endtask

  task automatic doEnv(int n);
    repeat (n) begin
      @(negedge clk); envTick = 1'b1;
      @(negedge clk); envTick = 1'b0;
    end
  endtask

  task automatic doPower();
    @(negedge clk); powerDn = 1'b1;
    @(negedge clk); powerDn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 reset state, R10 read masks
    expectV("R11 reset sample", 0, 0);
    expectV("R11 reset active", 1, 0);
    rd(2'd0, "R10 reset addr0", 8'h3F);
    rd(2'd1, "R10 reset addr1", 8'h00);
    rd(2'd2, "R10 addr2 reads ones", 8'hFF);
    rd(2'd3, "R10 reset addr3", 8'hBF);

    // R3 position frozen before first trigger
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'h07);
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'hC0);
    doTick(5);
    wr(2'd3, 8'h87);
    expectV("R6 trigger activates", 1, 1);
    expectV("R3 position still 0 at trigger", 0, 0);
    doTick(1); pos = 1;
    expectV("R2 step after one tick", 0, 15);

    // R4 pattern walk, every tick one step at f=2047
    for (int d = 0; d < 4; d++) begin
      wr(2'd0, 8'(d << 6));
      for (int k = 0; k < 8; k++) begin
        doTick(1);
        pos = (pos + 1) % 8;
        expectV($sformatf("R4 duty%0d pos%0d", d, pos), 0, patBit(d, pos) * 15);
      end
    end

    // R1 low byte kept across high write, R2 four ticks per step at f=2044
    wr(2'd2, 8'hFC);
    wr(2'd0, 8'hC0);
    wr(2'd3, 8'h87);
    for (int k = 1; k <= 32; k++) begin
      doTick(1);
      if (k % 4 == 0) pos = (pos + 1) % 8;
      expectV($sformatf("R1 R2 period tick%0d", k), 0, patBit(3, pos) * 15);
    end

    // R9 envelope
    wr(2'd1, 8'h71); wr(2'd3, 8'h87);
    expectV("R6 volume loads", 0, 7);
    doEnv(1); expectV("R9 falls by one", 0, 6);
    doEnv(2); expectV("R9 falls twice", 0, 4);
    wr(2'd1, 8'h3A); wr(2'd3, 8'h87);
    doEnv(1); expectV("R9 period2 holds", 0, 3);
    doEnv(1); expectV("R9 period2 rises", 0, 4);
    wr(2'd1, 8'hE9); wr(2'd3, 8'h87);
    doEnv(2); expectV("R9 saturates at 15", 0, 15);
    wr(2'd1, 8'h11); wr(2'd3, 8'h87);
    doEnv(2); expectV("R9 saturates at 0", 0, 0);
    expectV("R9 still active at 0", 1, 1);
    wr(2'd1, 8'h50); wr(2'd3, 8'h87);
    doEnv(3); expectV("R9 period0 holds", 0, 5);

    // R8 length counter
    wr(2'd1, 8'hF0); wr(2'd0, 8'hFF); wr(2'd3, 8'hC7);
    expectV("R8 active with count 1", 1, 1);
    rd(2'd3, "R10 addr3 length enable", 8'hFF);
    doLen(1);
    expectV("R8 expiry deactivates", 1, 0);
    expectV("R5 silent when inactive", 0, 0);
    wr(2'd3, 8'hC7);
    doLen(63); expectV("R8 reload 64 not yet", 1, 1);
    doLen(1);  expectV("R8 reload 64 expires", 1, 0);
    wr(2'd0, 8'hFF); wr(2'd3, 8'h87);
    rd(2'd3, "R10 addr3 no length enable", 8'hBF);
    doLen(3); expectV("R8 disabled ignores ticks", 1, 1);

    // R7 converter enable
    wr(2'd1, 8'h00);
    expectV("R7 disable deactivates", 1, 0);
    rd(2'd1, "R10 addr1 zero", 8'h00);
    wr(2'd3, 8'h87);
    expectV("R6 no activation with converter off", 1, 0);
    wr(2'd1, 8'h08); wr(2'd3, 8'h87);
    expectV("R7 direction bit enables converter", 1, 1);
    expectV("R5 zero volume gives zero", 0, 0);

    // R10 readback
    wr(2'd0, 8'h40);
    rd(2'd0, "R10 addr0 duty1", 8'h7F);
    wr(2'd1, 8'hA5);
    rd(2'd1, "R10 addr1 echo", 8'hA5);

    // R11 power-off clears all, including trigger-seen flag and position
    wr(2'd1, 8'hF0); wr(2'd0, 8'hC0); wr(2'd3, 8'h87);
    expectV("R11 active before power-off", 1, 1);
    doPower();
    expectV("R11 power-off inactive", 1, 0);
    rd(2'd0, "R11 power-off addr0", 8'h3F);
    rd(2'd1, "R11 power-off addr1", 8'h00);
    rd(2'd3, "R11 power-off addr3", 8'hBF);
    wr(2'd1, 8'hF0); wr(2'd0, 8'hC0); wr(2'd2, 8'hFF); wr(2'd3, 8'h07);
    doTick(3);
    wr(2'd3, 8'h87);
    expectV("R11 R3 position cleared and frozen", 0, 0);
    doTick(1);
    expectV("R11 steps after retrigger", 0, 15);

    @(negedge clk);
    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule